// File: doc/BRIEF.md
# Frame-synced serial deviation receiver

This block takes 16-bit frequency-deviation words from a three-wire serial link: a bit clock, a frame sync and a data line. The same three wires carry symbol inputs when the chip runs in its parallel symbol mode. The receiver only listens when serial mode is selected. A configuration bit picks which frame-sync level marks the data phase. Bits are sampled on each rising edge of the bit clock during that phase, most significant bit first.

When the frame sync leaves its active level, the last sixteen bits received are moved to a holding register. A valid strobe is raised for one bit-clock cycle at the same time. The phase that carries no data may be a single clock long, so one frame can be as short as 17 bit clocks and the link can run with frames back to back. The whole block runs in the bit-clock domain, which may run at up to 100 MHz.

Top module: `fsrx_deviation_rx`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `word_o` reads 0 and `valid_o` reads 0.
- R2: A data bit is taken on every rising edge of `sck_i` where `en_i` is 1 and `fs_i` equals `fs_pol_i`. Bits enter most significant bit first, so the first of 16 bits ends up in `word_o[15]`.
- R3: With `fs_pol_i` = 1, data is taken while `fs_i` is high. With `fs_pol_i` = 0, data is taken while `fs_i` is low.
- R4: On the first rising edge of the inactive phase after an active phase of at least 16 bits, `word_o` takes the word and `valid_o` goes to 1.
- R5: `valid_o` stays high for exactly one bit-clock cycle per completed frame.
- R6: If more than 16 bits arrive in one active phase, only the last 16 are kept.
- R7: If fewer than 16 bits arrive in one active phase, the frame is dropped. No valid strobe is raised and `word_o` keeps its previous value.
- R8: An inactive phase of a single bit clock is enough to close a frame. Frames of 17 clocks sent back to back are each delivered.
- R9: On an edge where `fs_pol_i` differs from its value at the previous edge, any partial or complete frame in progress is dropped, even if 16 bits were already collected. No strobe is raised for that frame.
- R10: While `en_i` is 0, the link is ignored. No strobe is raised and `word_o` is unchanged. A frame that was partly received is dropped.
- R11: `word_o` changes only on the edge that raises `valid_o`, and holds its value between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck_i | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Serial mode selected; 0 makes the receiver ignore the link |
| fs_pol_i | input | 1 | Frame-sync level that marks the data phase |
| fs_i | input | 1 | Frame sync |
| sd_i | input | 1 | Serial data |
| word_o | output | 16 | Last delivered deviation word |
| valid_o | output | 1 | One-cycle strobe when `word_o` is updated |

## Verification
The bench sends frames with active phases from 14 to 20 bits, under both frame-sync polarities. This separates dropping, exact capture and keeping the last 16 bits. Walking-one words confirm bit order, since any reversal or off-by-one shift puts the single set bit in the wrong place. Back-to-back frames with a one-clock gap confirm that the minimum frame length works. A full 16-bit frame cut off by a polarity flip tells an aborting receiver apart from one that simply sees the phase end. Frames sent with the mode disabled, and frames with the mode dropped partway through, confirm that the link is ignored and that the held word survives.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_BIT   = 2'd1,
    EV_END   = 2'd2,
    EV_ABORT = 2'd3
  } fsrx_ev_e;
endpackage

// File: rtl/fsrx_phase.sv
module fsrx_phase
  import fsrx_pkg::*;
#(
  parameter logic POL_RST = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     pol_i,
  input  logic     fs_i,
  output fsrx_ev_e ev_o
);
  logic pol_q, act_q;
  logic act, pol_chg;

  assign act     = en_i && (fs_i == pol_i);
  assign pol_chg = (pol_i != pol_q);

  always_comb begin
    if (!en_i || pol_chg) ev_o = EV_ABORT;
    else if (act)         ev_o = EV_BIT;
    else if (act_q)       ev_o = EV_END;
    else                  ev_o = EV_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= POL_RST;
      act_q <= 1'b0;
    end else begin
      pol_q <= pol_i;
      act_q <= act && !pol_chg;
    end
  end
endmodule

// File: rtl/fsrx_shift.sv
module fsrx_shift
  import fsrx_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fsrx_ev_e      ev_i,
  input  logic          sd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign data_o = sh_q;
  assign full_o = (cnt_q == CW'(DW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (ev_i)
        EV_BIT: begin
          sh_q <= {sh_q[DW-2:0], sd_i};
          if (!full_o) cnt_q <= cnt_q + CW'(1);
        end
        EV_END, EV_ABORT: cnt_q <= '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fsrx_hold.sv
module fsrx_hold #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] word_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) word_o <= data_i;
    end
  end
endmodule

// File: rtl/fsrx_deviation_rx.sv
module fsrx_deviation_rx
  import fsrx_pkg::*;
#(
  parameter int   DW      = 16,
  parameter logic POL_RST = 1'b1
) (
  input  logic          sck_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fs_pol_i,
  input  logic          fs_i,
  input  logic          sd_i,
  output logic [DW-1:0] word_o,
  output logic          valid_o
);
  fsrx_ev_e      ev;
  logic [DW-1:0] sh_data;
  logic          sh_full;
  logic          cap;

  fsrx_phase #(.POL_RST(POL_RST)) i_phase (
    .clk_i (sck_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .pol_i (fs_pol_i),
    .fs_i  (fs_i),
    .ev_o  (ev)
  );

  fsrx_shift #(.DW(DW)) i_shift (
    .clk_i (sck_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .sd_i  (sd_i),
    .data_o(sh_data),
    .full_o(sh_full)
  );

  // frames short of DW bits are dropped here
  assign cap = (ev == EV_END) && sh_full;

  fsrx_hold #(.DW(DW)) i_hold (
    .clk_i  (sck_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .data_i (sh_data),
    .word_o (word_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/fsrx_chk.sv
module fsrx_chk #(
  parameter int DW = 16
) (
  input logic          sck_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          fs_pol_i,
  input logic          fs_i,
  input logic [DW-1:0] word_o,
  input logic          valid_o
);
  p_valid_pulse_r5: assert property (@(posedge sck_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_word_hold_r11: assert property (@(posedge sck_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  p_end_of_phase_r4: assert property (@(posedge sck_i) disable iff (!rst_ni)
    valid_o |-> ($past(en_i) && $past(fs_i != fs_pol_i)
                 && $past(en_i && (fs_i == fs_pol_i), 2)));

  p_disabled_quiet_r10: assert property (@(posedge sck_i) disable iff (!rst_ni)
    !$past(en_i) |-> !valid_o);

  p_pol_flip_drop_r9: assert property (@(posedge sck_i) disable iff (!rst_ni)
    (fs_pol_i != $past(fs_pol_i)) |=> !valid_o);
endmodule

bind fsrx_deviation_rx fsrx_chk #(.DW(DW)) i_fsrx_chk (
  .sck_i   (sck_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .fs_pol_i(fs_pol_i),
  .fs_i    (fs_i),
  .word_o  (word_o),
  .valid_o (valid_o)
);

// File: tb/test_fsrx_deviation_rx.sv
module test_fsrx_deviation_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          sck, rst_n, en, pol, fs, sd;
  logic [DW-1:0] word;
  logic          valid;
  logic [DW-1:0] exp_word;
  int            total = 0;
  int            bad = 0;

  fsrx_deviation_rx #(.DW(DW)) i_fsrx_deviation_rx (
    .sck_i(sck), .rst_ni(rst_n), .en_i(en), .fs_pol_i(pol),
    .fs_i(fs), .sd_i(sd), .word_o(word), .valid_o(valid)
  );

  initial sck = 1'b0;
  always #(CLK_PERIOD/2) sck = ~sck;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic chk_out(input logic ev, input string req);
    chk(valid === ev, {req, " valid"}, {31'd0, valid}, {31'd0, ev});
    chk(word === exp_word, {req, " word"}, {16'd0, word}, {16'd0, exp_word});
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic send(input logic [31:0] pat, input int nbits, input int gap, input string req);
    for (int i = nbits - 1; i >= 0; i--) begin
      fs = pol; sd = pat[i];
      @(negedge sck);
    end
    fs = ~pol; sd = 1'b0;
    @(negedge sck);
    if (en && nbits >= DW) begin
      exp_word = pat[DW-1:0];
      chk_out(1'b1, req);
    end else chk_out(1'b0, req);
    for (int g = 1; g < gap; g++) begin
      @(negedge sck);
      chk_out(1'b0, "R5");
    end
  endtask

  task automatic set_pol(input logic p);
    pol = p; fs = ~p;
    @(negedge sck);
    @(negedge sck);
    chk_out(1'b0, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; pol = 1'b1; fs = 1'b0; sd = 1'b0;
    exp_word = '0;
    repeat (3) @(negedge sck);
    rst_n = 1'b1;
    @(negedge sck);
    chk_out(1'b0, "R1");

    // R2: walking one, both polarities (R3)
    for (int p = 1; p >= 0; p--) begin
      set_pol(p[0]);
      for (int b = 0; b < DW; b++) send(32'(1) << b, DW, 2, "R2");
    end

    // R6/R7/R4: lengths 14..20 under both polarities (R3)
    for (int p = 0; p < 2; p++) begin
      set_pol(p[0]);
      for (int n = 14; n <= 20; n++) begin
        logic [31:0] w;
        w = 32'h3C96_A5C3 ^ (32'(n) * 32'h0001_1357) ^ (32'(p) << 7);
        if (n < DW) send(w, n, 3, "R7");
        else if (n > DW) send(w, n, 3, "R6");
        else send(w, n, 3, "R4");
      end
    end

    // R8: back-to-back 17-clock frames
    set_pol(1'b1);
    for (int k = 0; k < 8; k++) send(32'hBEEF ^ (32'(k) * 32'h0F1D), DW, 1, "R8");
    set_pol(1'b0);
    for (int k = 0; k < 8; k++) send(32'h1234 + (32'(k) * 32'h2E71), DW, 1, "R8");

    // R9: full frame cut by polarity flip, fs level kept
    set_pol(1'b1);
    for (int i = DW - 1; i >= 0; i--) begin
      fs = 1'b1; sd = i[0];
      @(negedge sck);
    end
    pol = 1'b0;
    @(negedge sck);
    chk_out(1'b0, "R9");
    @(negedge sck);
    chk_out(1'b0, "R9");
    send(32'h7E81, DW, 2, "R9");

    // R10: disabled, whole frame ignored
    en = 1'b0;
    send(32'h5555, DW, 2, "R10");
    en = 1'b1;
    @(negedge sck);
    // R10: disable mid-frame, then resume bits
    for (int i = 0; i < 10; i++) begin
      fs = pol; sd = 1'b1;
      if (i == 4) en = 1'b0;
      if (i == 5) en = 1'b1;
      @(negedge sck);
    end
    fs = ~pol;
    @(negedge sck);
    chk_out(1'b0, "R10");
    send(32'hC0DE, DW, 2, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule